// File: doc/BRIEF.md
# Multiply-Step Arithmetic Unit

This block carries out one iteration of a shift-and-add multiplication per enabled clock. A 32-bit partial product enters on one port and a 32-bit multiplicand on another. The block keeps the multiplier bits in its own Y register and keeps a four-bit condition-flag register (negative, zero, overflow, carry).

On a step, the partial product is shifted right by one place. The exclusive-OR of the previous negative and overflow flags enters at the top. The multiplicand is added when the low bit of Y is set; otherwise zero is added. The low bit of the unshifted partial product moves into the top of Y as Y shifts right. All four flags are recomputed from the addition. The sum appears on a registered result output.

A sequencer runs a multiply by loading Y and the flags, then stepping repeatedly and feeding the result back as the next partial product. Direct load ports for Y and the flags act only on clocks with no step.

Top module: `mstep_unit`

## Requirements
- R1: A synchronous active-high reset clears Y, the flag register and the result to zero.
- R2: The shifted operand holds (N XOR V) of the flags held before the step in bit 31, and partial-product bits 31..1 in bits 30..0.
- R3: The addend is the multiplicand when Y bit 0 is 1 and zero when it is 0. The result, registered on the step edge, is the 32-bit sum of the shifted operand and the addend, with the carry out dropped.
- R4: On a step, Y becomes {partial-product input bit 0, Y[31:1]}.
- R5: On a step, Z is set exactly when the result is zero, and N equals result bit 31.
- R6: On a step, C is set exactly when the result is unsigned-less-than the shifted operand.
- R7: On a step, V equals bit 31 of (NOT(shifted XOR addend)) AND (shifted XOR result).
- R8: With no step, a Y load writes the load value into Y on the clock edge.
- R9: With no step, a flag load writes the four-bit value into the flags, where bit 3 is N, bit 2 is Z, bit 1 is V and bit 0 is C. The flag output uses the same bit order.
- R10: A load that coincides with a step is ignored; the step's values win.
- R11: With neither a step nor a load, Y, the flags and the result keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Perform one multiply step this clock |
| pp_in | input | 32 | Partial-product operand |
| mcand | input | 32 | Multiplicand |
| y_wr | input | 1 | Load Y when no step |
| y_wr_val | input | 32 | Value for a Y load |
| flg_wr | input | 1 | Load flags when no step |
| flg_wr_val | input | 4 | Value for a flag load (N,Z,V,C from bit 3 down) |
| result | output | 32 | Registered sum of the last step |
| y_val | output | 32 | Current Y register |
| flags | output | 4 | Current flags (N,Z,V,C from bit 3 down) |

## Verification
The hardest case to reach from the ports is a step whose shifted-in top bit comes from flags that differ from what the previous step would have produced, together with an addition that both wraps to zero and overflows. The stimulus reaches it by loading chosen N and V values straight into the flags, loading Y with an odd value, and then stepping with a partial product of zero and a multiplicand of 0x80000000. Long chains of 33 random steps, with each result fed back, then cover the flag feedback between steps.

// File: rtl/mstep_pkg.sv
package mstep_pkg;

    localparam int unsigned DW = 32;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    typedef struct packed {
        logic [DW-1:0] shifted;
        logic [DW-1:0] addend;
    } operands_t;

    typedef struct packed {
        logic [DW-1:0] sum;
        flags_t        flg;
    } step_out_t;

    function automatic logic sign_bit(input logic [DW-1:0] x);
        return x[DW-1];
    endfunction

endpackage

// File: rtl/mstep_operand.sv
module mstep_operand
    import mstep_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] pp_in,
    input  logic [W-1:0] mcand,
    input  logic         y_lsb,
    input  flags_t       prev_flg,
    output logic [W-1:0] shifted,
    output logic [W-1:0] addend
);
    logic top_bit;

    always_comb begin
        top_bit = prev_flg.n ^ prev_flg.v;
        shifted = {top_bit, pp_in[W-1:1]};
        addend  = y_lsb ? mcand : '0;
    end

    always_comb begin
        if (!y_lsb) begin
            a_r3_zero_addend: assert (addend == '0);
        end
    end
endmodule

// File: rtl/mstep_adder.sv
module mstep_adder
    import mstep_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic [W-1:0] shifted,
    input  logic [W-1:0] addend,
    output logic [W-1:0] sum,
    output flags_t       flg
);
    localparam int unsigned XW = W + 1;

    logic [XW-1:0] wide;
    logic          sa_same;
    logic          sr_diff;

    always_comb begin
        wide    = {1'b0, shifted} + {1'b0, addend};
        sum     = wide[W-1:0];
        sa_same = shifted[W-1] ~^ addend[W-1];
        sr_diff = shifted[W-1] ^ sum[W-1];
        flg.n   = sum[W-1];
        flg.z   = (sum == '0);
        flg.v   = sa_same & sr_diff;
        flg.c   = wide[W];
    end

    always_comb begin
        a_r6_carry_compare: assert (flg.c == (sum < shifted));
    end
endmodule

// File: rtl/mstep_state.sv
module mstep_state
    import mstep_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic [W-1:0] next_sum,
    input  flags_t       next_flg,
    input  logic         pp_lsb,
    input  logic         y_wr,
    input  logic [W-1:0] y_wr_val,
    input  logic         flg_wr,
    input  flags_t       flg_wr_val,
    output logic [W-1:0] res_q,
    output logic [W-1:0] y_q,
    output flags_t       flg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            y_q   <= '0;
            flg_q <= '0;
        end else if (step_en) begin
            res_q <= next_sum;
            y_q   <= {pp_lsb, y_q[W-1:1]};
            flg_q <= next_flg;
        end else begin
            if (y_wr) begin
                y_q <= y_wr_val;
            end
            if (flg_wr) begin
                flg_q <= flg_wr_val;
            end
        end
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (res_q == '0 && y_q == '0 && flg_q == '0));

    a_r4_y_shift: assert property (@(posedge clk) disable iff (rst)
        step_en |=> y_q == {$past(pp_lsb), $past(y_q[W-1:1])});

    a_r5_zero_flag: assert property (@(posedge clk) disable iff (rst)
        step_en |=> flg_q.z == (res_q == '0));

    a_r5_neg_flag: assert property (@(posedge clk) disable iff (rst)
        step_en |=> flg_q.n == res_q[W-1]);

    a_r8_y_load: assert property (@(posedge clk) disable iff (rst)
        (!step_en && y_wr) |=> y_q == $past(y_wr_val));

    a_r9_flag_load: assert property (@(posedge clk) disable iff (rst)
        (!step_en && flg_wr) |=> flg_q == $past(flg_wr_val));

    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (!step_en && !y_wr && !flg_wr) |=>
            ($stable(y_q) && $stable(flg_q) && $stable(res_q)));
endmodule

// File: rtl/mstep_unit.sv
module mstep_unit
    import mstep_pkg::*;
#(
    parameter int unsigned W = DW
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic [W-1:0] pp_in,
    input  logic [W-1:0] mcand,
    input  logic         y_wr,
    input  logic [W-1:0] y_wr_val,
    input  logic         flg_wr,
    input  logic [3:0]   flg_wr_val,
    output logic [W-1:0] result,
    output logic [W-1:0] y_val,
    output logic [3:0]   flags
);
    logic [W-1:0] shifted;
    logic [W-1:0] addend;
    logic [W-1:0] sum;
    flags_t       new_flg;
    flags_t       cur_flg;
    flags_t       wr_flg;

    assign wr_flg = flags_t'(flg_wr_val);

    mstep_operand #(.W(W)) u_operand (
        .pp_in    (pp_in),
        .mcand    (mcand),
        .y_lsb    (y_val[0]),
        .prev_flg (cur_flg),
        .shifted  (shifted),
        .addend   (addend)
    );

    mstep_adder #(.W(W)) u_adder (
        .shifted (shifted),
        .addend  (addend),
        .sum     (sum),
        .flg     (new_flg)
    );

    mstep_state #(.W(W)) u_state (
        .clk        (clk),
        .rst        (rst),
        .step_en    (step_en),
        .next_sum   (sum),
        .next_flg   (new_flg),
        .pp_lsb     (pp_in[0]),
        .y_wr       (y_wr),
        .y_wr_val   (y_wr_val),
        .flg_wr     (flg_wr),
        .flg_wr_val (wr_flg),
        .res_q      (result),
        .y_q        (y_val),
        .flg_q      (cur_flg)
    );

    assign flags = cur_flg;

    a_r2_top_bit: assert property (@(posedge clk) disable iff (rst)
        step_en |=> $past(shifted[W-1]) == ($past(flags[3]) ^ $past(flags[1])));

    a_r3_sum: assert property (@(posedge clk) disable iff (rst)
        step_en |=> result == $past(shifted) + $past(addend));

    a_r7_overflow: assert property (@(posedge clk) disable iff (rst)
        step_en |=> flags[1] == (sign_bit($past(shifted)) == sign_bit($past(addend))
                                 && sign_bit(result) != sign_bit($past(shifted))));

    a_r10_step_wins: assert property (@(posedge clk) disable iff (rst)
        (step_en && flg_wr) |=> flags[2] == (result == '0));
endmodule

// File: tb/mstep_unit_tb.sv
module mstep_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        step_en;
    logic [31:0] pp_in, mcand, y_wr_val;
    logic        y_wr, flg_wr;
    logic [3:0]  flg_wr_val;
    logic [31:0] result, y_val;
    logic [3:0]  flags;

    int total = 0;
    int bad = 0;

    bit [31:0] m_res, m_y;
    bit [3:0]  m_flg;

    always #(CLK_PERIOD/2) clk = ~clk;

    mstep_unit u_dut (
        .clk(clk), .rst(rst), .step_en(step_en), .pp_in(pp_in), .mcand(mcand),
        .y_wr(y_wr), .y_wr_val(y_wr_val), .flg_wr(flg_wr), .flg_wr_val(flg_wr_val),
        .result(result), .y_val(y_val), .flags(flags)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R3 result"}, result, m_res);
        chk({tag, " R4 y"}, y_val, m_y);
        chk({tag, " R5 N"}, {31'd0, flags[3]}, {31'd0, m_flg[3]});
        chk({tag, " R5 Z"}, {31'd0, flags[2]}, {31'd0, m_flg[2]});
        chk({tag, " R7 V"}, {31'd0, flags[1]}, {31'd0, m_flg[1]});
        chk({tag, " R6 C"}, {31'd0, flags[0]}, {31'd0, m_flg[0]});
    endtask

    // behavioural model of one clock; inputs already driven
    task automatic model_clock();
        bit [31:0] sh, ad, rs;
        bit [32:0] full;
        if (step_en) begin
            sh = {m_flg[3] ^ m_flg[1], pp_in[31:1]};   // R2
            ad = m_y[0] ? mcand : 32'd0;
            full = {1'b0, sh} + {1'b0, ad};
            rs = full[31:0];
            m_res = rs;
            m_y = {pp_in[0], m_y[31:1]};
            m_flg[3] = rs[31];
            m_flg[2] = (rs == 0);
            m_flg[1] = ~(sh[31] ^ ad[31]) & (sh[31] ^ rs[31]);
            m_flg[0] = (rs < sh);
        end else begin
            if (y_wr) m_y = y_wr_val;
            if (flg_wr) m_flg = flg_wr_val;
        end
    endtask

    task automatic cyc(input logic s, input logic [31:0] p, input logic [31:0] m,
                       input logic yw, input logic [31:0] yv,
                       input logic fw, input logic [3:0] fv, input string tag);
        step_en = s; pp_in = p; mcand = m;
        y_wr = yw; y_wr_val = yv; flg_wr = fw; flg_wr_val = fv;
        model_clock();
        @(posedge clk);
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; step_en = 0; pp_in = '1; mcand = '1;
        y_wr = 1; y_wr_val = '1; flg_wr = 1; flg_wr_val = 4'hF;
        m_res = 0; m_y = 0; m_flg = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_all("R1 reset");
        rst = 1'b0;

        // R8, R9 loads
        cyc(0, 0, 0, 1, 32'hDEAD_BEEF, 0, 4'h0, "R8 yload");
        cyc(0, 0, 0, 0, 0, 1, 4'b1010, "R9 flgload");
        // R11 idle hold
        cyc(0, 32'h1234_5678, 32'h1, 0, 0, 0, 4'h0, "R11 idle");
        // R2: N=1,V=0 -> top bit 1; Y odd; 0 + 0x80000000 wraps (R3,R5,R6,R7)
        cyc(0, 0, 0, 1, 32'h0000_0001, 1, 4'b1000, "R2 setup");
        cyc(1, 32'h0, 32'h8000_0000, 0, 0, 0, 4'h0, "R2 wrap");
        // R3: Y even -> addend zero
        cyc(0, 0, 0, 1, 32'h0000_0002, 1, 4'b1010, "R3 setup");
        cyc(1, 32'hFFFF_FFFF, 32'h7777_7777, 0, 0, 0, 4'h0, "R3 gated");
        // R10: loads during step ignored
        cyc(1, 32'h0000_0003, 32'h1111_1111, 1, 32'hAAAA_5555, 1, 4'b0110, "R10 collide");
        cyc(0, 0, 0, 0, 0, 0, 0, "R11 idle2");

        // chained random runs of 33 steps
        for (int run = 0; run < 20; run++) begin
            cyc(0, 0, 0, 1, $urandom, 1, 4'($urandom), "chain load");
            begin
                logic [31:0] mc;
                logic [31:0] pp;
                mc = $urandom;
                pp = (run % 2 == 0) ? 32'd0 : $urandom;
                for (int k = 0; k < 33; k++) begin
                    cyc(1, pp, mc, 0, 0, 0, 0, "R2 chain");
                    pp = result;
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule